// File: doc/BRIEF.md
# Programmable Wait-State READY Generator

This block stretches processor bus cycles for slow memory or IO devices. Address decode supplies a cycle strobe, which stays high for the whole access, and a 3-bit wait count. The block drives the processor's READY input low for exactly the programmed number of processor sample points, from 0 to 7. Each low sample inserts one wait state between T2 and T3. READY then goes high again in time for the sample that lets T3 proceed.

The rising edge of the strobe is detected synchronously. On that clock edge the count is loaded into a down-counter, which then decrements once per clock. READY is high whenever the counter is zero or the strobe is low. The counter is cleared synchronously, so a clear never races the counting edge. A strobe that drops in mid-count aborts the stretch at once. One clock period stands for one READY sample point, which is the end of T2 or the middle of each Tw.

Top module: `wait_ready_gen`

## Requirements
- R1: While `rst_n` is low, and after reset with no strobe, `ready` is 1.
- R2: A start is a clock edge at which `strobe` is 1 and was 0 at the previous edge. At that edge the counter loads the value of `wait_n`, which is an unsigned count of wait states.
- R3: After a start with `wait_n` = N > 0 and `strobe` held high, `ready` is 0 during exactly the N clock periods that follow the start edge. It is 1 from the period after those.
- R4: After a start with `wait_n` = 0, `ready` stays 1 for the whole cycle.
- R5: Changes on `wait_n` after the start edge have no effect on the number of low periods of that cycle.
- R6: When `strobe` goes low, `ready` is 1 in the same period and the counter is cleared at the next edge. A later start counts the full new value.
- R7: While `strobe` stays high after the count has finished, `ready` stays 1 and the counter does not reload.
- R8: The counter decrements by exactly one per clock and never wraps below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each rising edge is one READY sample point |
| rst_n | input | 1 | Synchronous reset, active low |
| strobe | input | 1 | Cycle strobe from address decode, high during the access |
| wait_n | input | CNT_W | Number of wait states for the cycle, taken at the start edge |
| ready | output | 1 | READY to the processor, low while wait states are to be inserted |

## Verification
Every count from 0 to 7 is run with the strobe held well past the end of the count. This separates an exact N-period stretch from one that is off by one, and it shows that the counter neither reloads nor wraps once it reaches zero. In one cycle `wait_n` is changed while the count is running. This tells a count latched at the start edge apart from one that follows the live input. Another cycle drops the strobe in the middle of a count and then restarts with a new value. This separates an immediate abort from a stretch that keeps running, and a fresh load from a leftover count.

// File: rtl/wait_ready_gen.sv
module wait_ready_gen #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic [CNT_W-1:0] wait_n,
  output logic             ready
);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic             strobe_q;
  logic [CNT_W-1:0] cnt;
  logic             start;

  assign start = strobe & ~strobe_q;
  assign ready = (cnt == ZERO) | ~strobe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      cnt      <= ZERO;
    end else begin
      strobe_q <= strobe;
      if (!strobe)
        cnt <= ZERO;
      else if (start)
        cnt <= wait_n;
      else if (cnt != ZERO)
        cnt <= cnt - 1'b1;
    end
  end
endmodule

module wait_ready_gen_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             strobe,
  input logic             strobe_q,
  input logic [CNT_W-1:0] wait_n,
  input logic [CNT_W-1:0] cnt,
  input logic             ready
);
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !strobe_q) |=> (cnt == $past(wait_n)));

  p_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && strobe_q && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |-> ready);

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> (cnt == '0));

  p_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && strobe_q && cnt == '0) |=> (cnt == '0));
endmodule

bind wait_ready_gen wait_ready_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .strobe(strobe), .strobe_q(strobe_q),
  .wait_n(wait_n), .cnt(cnt), .ready(ready)
);

// File: tb/sim_wait_ready_gen.sv
module sim_wait_ready_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strobe = 1'b0;
  logic [2:0] wait_n = '0;
  logic       ready;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit    exp_q[$];
  string tag_q[$];

  wait_ready_gen #(.CNT_W(3)) u0 (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .wait_n(wait_n), .ready(ready)
  );

  always #2 clk = ~clk;

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      mismatched++;
      $display("FAIL watchdog: actual=hung expected=done");
      report();
    end
  end

  // Monitor: value seen just after the negedge is what the next sample point sees
  always @(negedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      bit e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      compared++;
      if (ready !== e) begin
        mismatched++;
        $display("FAIL %s: actual=%b expected=%b", t, ready, e);
      end
    end
  end

  task automatic step(input bit s, input logic [2:0] w, input bit e, input string t);
    @(negedge clk);
    strobe = s;
    wait_n = w;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  // Start with count n, hold strobe for len periods; wait_n becomes alt after the start
  task automatic run(input int n, input int len, input logic [2:0] alt, input string t);
    step(1'b1, 3'(n), 1'b1, {t, " start"});
    for (int i = 0; i < len; i++)
      step(1'b1, alt, (i < n) ? 1'b0 : 1'b1, t);
    step(1'b0, alt, 1'b1, {t, " R6 release"});
    step(1'b0, alt, 1'b1, {t, " idle"});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    compared++;
    if (ready !== 1'b1) begin
      mismatched++;
      $display("FAIL R1 in reset: actual=%b expected=1", ready);
    end
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 3'd5, 1'b1, "R1 idle after reset");
    step(1'b0, 3'd5, 1'b1, "R1 idle after reset");

    run(0, 4, 3'd0, "R4 zero wait");
    for (int n = 1; n < 8; n++)
      run(n, n + 3, 3'(n), "R3 R2 R8 R7 count");

    run(5, 8, 3'd1, "R5 late change down");
    run(2, 5, 3'd7, "R5 late change up");

    run(6, 2, 3'd6, "R6 abort");
    run(3, 6, 3'd3, "R6 fresh restart");

    step(1'b1, 3'd7, 1'b1, "R7 start");
    for (int i = 0; i < 7; i++) step(1'b1, 3'd7, 1'b0, "R3 seven");
    for (int i = 0; i < 6; i++) step(1'b1, 3'd7, 1'b1, "R7 no reload");
    step(1'b0, 3'd0, 1'b1, "R6 release");

    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    report();
  end
endmodule